// File: doc/BRIEF.md
# Dual-Lane Vector Shuffle and Merge Unit

This block rearranges the two 64-bit lanes of 128-bit vector operands. Each accepted operation is chosen by a 4-bit opcode. The available operations are:

- a cross-operand lane shuffle steered by a 2-bit immediate;
- interleaves of the two upper lanes or of the two lower lanes;
- half-register merges of a 64-bit memory datum, which keep the other half;
- a scalar low-lane move;
- extraction of both lane sign bits into a general-purpose result;
- full-width moves, in an aligned form and an unaligned form.

The aligned full-width move checks its byte address against a 16-byte boundary. When the address is off that boundary, the move raises a fault and does not change the vector result.

The unit sits beside a register file. The issuing logic presents the operands, the memory datum, the address, the opcode and the immediate together with a valid strobe. All results are registered. The vector result, the general-purpose result and the fault flag hold their values until an operation that owns them is accepted. This unit performs no memory access itself.

Top module: `lane_permute_unit`

## Requirements
- R1: While rst_n is low, and after it is released with no operation accepted, vec_q, gpr_q and fault_q are all zero.
- R2: Opcode 0 (shuffle): vec_q[63:0] takes a[127:64] when imm_i[0]=1 and takes a[63:0] otherwise. vec_q[127:64] takes b[127:64] when imm_i[1]=1 and takes b[63:0] otherwise.
- R3: Opcode 1 (upper interleave): vec_q = {b[127:64], a[127:64]}. The lower lanes of both operands have no effect.
- R4: Opcode 2 (lower interleave): vec_q = {b[63:0], a[63:0]}. The upper lanes of both operands have no effect.
- R5: Opcode 3 (upper merge) gives vec_q = {mem_i, a[63:0]}. Opcode 4 (lower merge) gives vec_q = {a[127:64], mem_i}.
- R6: Opcode 5 (scalar move): vec_q = {a[127:64], b[63:0]}. Only the low 64 bits come from b.
- R7: Opcode 8 (sign extract): gpr_q[0] = a[63] and gpr_q[1] = a[127], with gpr_q[31:2] zero. vec_q does not change.
- R8: Opcode 6 (aligned move): when addr_i mod 16 is 0, vec_q = b and fault_q = 0. Otherwise fault_q = 1 and vec_q keeps its previous value.
- R9: Opcode 7 (unaligned move): vec_q = b and fault_q = 0 for any address.
- R10: Every defined opcode except a faulting aligned move clears fault_q. gpr_q changes only on opcode 8.
- R11: When valid_i is low, or the opcode is 9 to 15, vec_q, gpr_q and fault_q all keep their values.
- R12: The results of an operation accepted at a rising edge appear at that same edge, one register stage after the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| imm_i | input | 2 | Shuffle lane selects |
| src_a_i | input | 128 | First vector operand (destination value) |
| src_b_i | input | 128 | Second vector operand |
| mem_i | input | 64 | Memory datum for half merges |
| addr_i | input | 32 | Byte address for full-width moves |
| vec_q | output | 128 | Registered vector result |
| gpr_q | output | 32 | Registered general-purpose result |
| fault_q | output | 1 | Registered alignment fault |

## Verification
Every result of this unit passes through exactly one register. An operation driven before a rising edge therefore shows its vector result, sign mask and fault flag right after that edge. The bench drives inputs on the falling edge and drops valid at the next falling edge. It reads all three outputs at that point, when they already reflect the edge between those two falling edges and no later operation has been accepted. The hold cases use the same read point. The bench first loads a known vector with an idle or ignored operation, then reads it back unchanged at the same point.

// File: rtl/lpu_pkg.sv
package lpu_pkg;

    typedef enum logic [3:0] {
        OP_SHUF      = 4'd0,
        OP_UNPK_HI   = 4'd1,
        OP_UNPK_LO   = 4'd2,
        OP_MERGE_HI  = 4'd3,
        OP_MERGE_LO  = 4'd4,
        OP_MOV_SCL   = 4'd5,
        OP_MOV_ALGN  = 4'd6,
        OP_MOV_UALGN = 4'd7,
        OP_SIGN_EXT  = 4'd8
    } lpu_op_e;

    localparam int unsigned LPU_OP_W = 4;

endpackage

// File: rtl/lpu_lane_route.sv
module lpu_lane_route #(
    parameter int unsigned LANE_W = 64,
    localparam int unsigned VEC_W = 2 * LANE_W
) (
    input  logic [VEC_W-1:0]  a_i,
    input  logic [VEC_W-1:0]  b_i,
    input  logic [LANE_W-1:0] mem_i,
    input  logic [1:0]        sel_i,
    output logic [VEC_W-1:0]  shuf_o,
    output logic [VEC_W-1:0]  unpk_hi_o,
    output logic [VEC_W-1:0]  unpk_lo_o,
    output logic [VEC_W-1:0]  merge_hi_o,
    output logic [VEC_W-1:0]  merge_lo_o,
    output logic [VEC_W-1:0]  mov_scl_o
);
    logic [LANE_W-1:0] a_lo, a_hi, b_lo, b_hi;

    always_comb begin
        a_lo = a_i[LANE_W-1:0];
        a_hi = a_i[VEC_W-1:LANE_W];
        b_lo = b_i[LANE_W-1:0];
        b_hi = b_i[VEC_W-1:LANE_W];

        shuf_o     = {(sel_i[1] ? b_hi : b_lo), (sel_i[0] ? a_hi : a_lo)};
        unpk_hi_o  = {b_hi, a_hi};
        unpk_lo_o  = {b_lo, a_lo};
        merge_hi_o = {mem_i, a_lo};
        merge_lo_o = {a_hi, mem_i};
        mov_scl_o  = {a_hi, b_lo};
    end
endmodule

// File: rtl/lpu_sign_gather.sv
module lpu_sign_gather #(
    parameter int unsigned LANE_W = 64,
    parameter int unsigned LANES  = 2,
    parameter int unsigned OUT_W  = 32,
    localparam int unsigned VEC_W = LANES * LANE_W
) (
    input  logic [VEC_W-1:0] vec_i,
    output logic [OUT_W-1:0] mask_o
);
    logic [LANES-1:0] signs;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign signs[g] = vec_i[(g+1)*LANE_W-1];
    end

    always_comb begin
        mask_o = '0;
        mask_o[LANES-1:0] = signs;
    end
endmodule

// File: rtl/lpu_align_check.sv
module lpu_align_check #(
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ALIGN_BYTES = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              misaligned_o
);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = ADDR_W'(ALIGN_BYTES - 1);

    always_comb misaligned_o = (addr_i & ALIGN_MASK) != '0;
endmodule

// File: rtl/lane_permute_unit.sv
module lane_permute_unit
    import lpu_pkg::*;
#(
    parameter int unsigned LANE_W      = 64,
    parameter int unsigned GPR_W       = 32,
    parameter int unsigned ADDR_W      = 32,
    parameter int unsigned ALIGN_BYTES = 16,
    localparam int unsigned VEC_W      = 2 * LANE_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_i,
    input  logic [LPU_OP_W-1:0] op_i,
    input  logic [1:0]          imm_i,
    input  logic [VEC_W-1:0]    src_a_i,
    input  logic [VEC_W-1:0]    src_b_i,
    input  logic [LANE_W-1:0]   mem_i,
    input  logic [ADDR_W-1:0]   addr_i,
    output logic [VEC_W-1:0]    vec_q,
    output logic [GPR_W-1:0]    gpr_q,
    output logic                fault_q
);
    typedef struct packed {
        logic [VEC_W-1:0] vec;
        logic [GPR_W-1:0] gpr;
        logic             fault;
    } lpu_state_t;

    lpu_state_t state_d, state_q;

    logic [VEC_W-1:0] shuf_w, unpk_hi_w, unpk_lo_w;
    logic [VEC_W-1:0] merge_hi_w, merge_lo_w, mov_scl_w;
    logic [GPR_W-1:0] sign_w;
    logic             misaligned_w;

    lpu_lane_route #(.LANE_W(LANE_W)) u_route (
        .a_i        (src_a_i),
        .b_i        (src_b_i),
        .mem_i      (mem_i),
        .sel_i      (imm_i),
        .shuf_o     (shuf_w),
        .unpk_hi_o  (unpk_hi_w),
        .unpk_lo_o  (unpk_lo_w),
        .merge_hi_o (merge_hi_w),
        .merge_lo_o (merge_lo_w),
        .mov_scl_o  (mov_scl_w)
    );

    lpu_sign_gather #(.LANE_W(LANE_W), .LANES(2), .OUT_W(GPR_W)) u_sign (
        .vec_i  (src_a_i),
        .mask_o (sign_w)
    );

    lpu_align_check #(.ADDR_W(ADDR_W), .ALIGN_BYTES(ALIGN_BYTES)) u_align (
        .addr_i       (addr_i),
        .misaligned_o (misaligned_w)
    );

    always_comb begin
        state_d = state_q;
        if (valid_i) begin
            case (op_i)
                OP_SHUF:      begin state_d.vec = shuf_w;     state_d.fault = 1'b0; end
                OP_UNPK_HI:   begin state_d.vec = unpk_hi_w;  state_d.fault = 1'b0; end
                OP_UNPK_LO:   begin state_d.vec = unpk_lo_w;  state_d.fault = 1'b0; end
                OP_MERGE_HI:  begin state_d.vec = merge_hi_w; state_d.fault = 1'b0; end
                OP_MERGE_LO:  begin state_d.vec = merge_lo_w; state_d.fault = 1'b0; end
                OP_MOV_SCL:   begin state_d.vec = mov_scl_w;  state_d.fault = 1'b0; end
                OP_MOV_UALGN: begin state_d.vec = src_b_i;    state_d.fault = 1'b0; end
                OP_MOV_ALGN: begin
                    if (misaligned_w) begin
                        state_d.fault = 1'b1;
                    end else begin
                        state_d.vec   = src_b_i;
                        state_d.fault = 1'b0;
                    end
                end
                OP_SIGN_EXT:  begin state_d.gpr = sign_w;     state_d.fault = 1'b0; end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign vec_q   = state_q.vec;
    assign gpr_q   = state_q.gpr;
    assign fault_q = state_q.fault;
endmodule

// File: rtl/lpu_checker.sv
module lpu_checker #(
    parameter int unsigned LANE_W = 64,
    parameter int unsigned GPR_W  = 32,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned VEC_W = 2 * LANE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              valid_i,
    input logic [3:0]        op_i,
    input logic [VEC_W-1:0]  src_a_i,
    input logic [VEC_W-1:0]  src_b_i,
    input logic [LANE_W-1:0] mem_i,
    input logic [ADDR_W-1:0] addr_i,
    input logic [VEC_W-1:0]  vec_q,
    input logic [GPR_W-1:0]  gpr_q,
    input logic              fault_q
);
    a_r5_merge_hi: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd3) |=>
            (vec_q[LANE_W-1:0] == $past(src_a_i[LANE_W-1:0]) &&
             vec_q[VEC_W-1:LANE_W] == $past(mem_i)));

    a_r7_gpr_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        gpr_q[GPR_W-1:2] == '0);

    a_r8_fault_keeps_vec: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd6 && addr_i[3:0] != 4'd0) |=>
            (fault_q && $stable(vec_q)));

    a_r9_unaligned_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i == 4'd7) |=> (!fault_q && vec_q == $past(src_b_i)));

    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid_i) |=> ($stable(vec_q) && $stable(gpr_q) && $stable(fault_q)));

    a_r10_gpr_only_on_sign: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && op_i != 4'd8) |=> $stable(gpr_q));
endmodule

bind lane_permute_unit lpu_checker #(
    .LANE_W (LANE_W),
    .GPR_W  (GPR_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .op_i    (op_i),
    .src_a_i (src_a_i),
    .src_b_i (src_b_i),
    .mem_i   (mem_i),
    .addr_i  (addr_i),
    .vec_q   (vec_q),
    .gpr_q   (gpr_q),
    .fault_q (fault_q)
);

// File: tb/sim_lane_permute_unit.sv
`timescale 1ns/1ps
module sim_lane_permute_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         valid_i = 1'b0;
    logic [3:0]   op_i = '0;
    logic [1:0]   imm_i = '0;
    logic [127:0] src_a_i = '0;
    logic [127:0] src_b_i = '0;
    logic [63:0]  mem_i = '0;
    logic [31:0]  addr_i = '0;
    logic [127:0] vec_q;
    logic [31:0]  gpr_q;
    logic         fault_q;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    lane_permute_unit u0 (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .op_i(op_i), .imm_i(imm_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .mem_i(mem_i), .addr_i(addr_i),
        .vec_q(vec_q), .gpr_q(gpr_q), .fault_q(fault_q)
    );

    localparam logic [127:0] A0 = {64'h8111_2222_3333_4444, 64'h0555_6666_7777_8888};
    localparam logic [127:0] B0 = {64'h0AAA_BBBB_CCCC_DDDD, 64'hFEEE_1111_0000_9999};
    localparam logic [63:0]  M0 = 64'h1234_5678_9ABC_DEF0;

    task automatic chk_vec(string req, logic [127:0] got, logic [127:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s vec actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic chk_gpr(string req, logic [31:0] got, logic [31:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s gpr actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic chk_bit(string req, logic got, logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s fault actual=%b expected=%b", req, got, exp);
        end
    endtask

    // drive at a falling edge, accept at the rising edge, read at the next falling edge
    task automatic issue(input logic v, input logic [3:0] op, input logic [1:0] imm,
                         input logic [127:0] a, input logic [127:0] b,
                         input logic [63:0] m, input logic [31:0] ad);
        @(negedge clk);
        valid_i = v; op_i = op; imm_i = imm;
        src_a_i = a; src_b_i = b; mem_i = m; addr_i = ad;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic t_reset();
        chk_vec("R1", vec_q, '0);
        chk_gpr("R1", gpr_q, '0);
        chk_bit("R1", fault_q, 1'b0);
    endtask

    task automatic t_shuffle();
        for (int s = 0; s < 4; s++) begin
            logic [127:0] e;
            e[63:0]   = s[0] ? A0[127:64] : A0[63:0];
            e[127:64] = s[1] ? B0[127:64] : B0[63:0];
            issue(1'b1, 4'd0, s[1:0], A0, B0, M0, 32'h0);
            chk_vec("R2", vec_q, e);   // R12 same edge
        end
    endtask

    task automatic t_unpack();
        issue(1'b1, 4'd1, 2'b00, A0, B0, M0, 32'h0);
        chk_vec("R3", vec_q, {B0[127:64], A0[127:64]});
        issue(1'b1, 4'd1, 2'b00, {A0[127:64], 64'hFFFF}, {B0[127:64], 64'h1}, M0, 32'h0);
        chk_vec("R3 low ignored", vec_q, {B0[127:64], A0[127:64]});
        issue(1'b1, 4'd2, 2'b11, A0, B0, M0, 32'h0);
        chk_vec("R4", vec_q, {B0[63:0], A0[63:0]});
        issue(1'b1, 4'd2, 2'b11, {64'h5, A0[63:0]}, {64'h7, B0[63:0]}, M0, 32'h0);
        chk_vec("R4 high ignored", vec_q, {B0[63:0], A0[63:0]});
    endtask

    task automatic t_merge();
        issue(1'b1, 4'd3, 2'b00, A0, B0, M0, 32'h0);
        chk_vec("R5 hi", vec_q, {M0, A0[63:0]});
        issue(1'b1, 4'd4, 2'b00, A0, B0, M0, 32'h0);
        chk_vec("R5 lo", vec_q, {A0[127:64], M0});
    endtask

    task automatic t_scalar();
        issue(1'b1, 4'd5, 2'b00, A0, B0, M0, 32'h0);
        chk_vec("R6", vec_q, {A0[127:64], B0[63:0]});
    endtask

    task automatic t_sign();
        for (int s = 0; s < 4; s++) begin
            logic [127:0] a;
            a = A0;
            a[63]  = s[0];
            a[127] = s[1];
            issue(1'b1, 4'd7, 2'b00, A0, B0, M0, 32'h3);
            issue(1'b1, 4'd8, 2'b00, a, '0, M0, 32'h0);
            chk_gpr("R7", gpr_q, {30'd0, s[1:0]});
            chk_vec("R7 vec kept", vec_q, B0);
        end
    endtask

    task automatic t_align();
        issue(1'b1, 4'd6, 2'b00, A0, B0, M0, 32'h0000_1230);
        chk_vec("R8 aligned", vec_q, B0);
        chk_bit("R8 aligned", fault_q, 1'b0);
        issue(1'b1, 4'd6, 2'b00, A0, A0, M0, 32'h0000_1238);
        chk_bit("R8 misaligned", fault_q, 1'b1);
        chk_vec("R8 vec kept", vec_q, B0);
        issue(1'b1, 4'd6, 2'b00, A0, A0, M0, 32'h0000_0001);
        chk_bit("R8 addr 1", fault_q, 1'b1);
        issue(1'b1, 4'd0, 2'b00, A0, B0, M0, 32'h0);
        chk_bit("R10 fault cleared", fault_q, 1'b0);
        issue(1'b1, 4'd7, 2'b00, A0, A0, M0, 32'h0000_100F);
        chk_vec("R9", vec_q, A0);
        chk_bit("R9", fault_q, 1'b0);
    endtask

    task automatic t_hold();
        logic [127:0] v;
        logic [31:0]  g;
        v = vec_q; g = gpr_q;
        issue(1'b0, 4'd7, 2'b00, B0, B0, M0, 32'h0);
        chk_vec("R11 idle", vec_q, v);
        issue(1'b1, 4'd6, 2'b00, A0, A0, M0, 32'h4);
        issue(1'b1, 4'd9, 2'b00, B0, B0, M0, 32'h0);
        chk_vec("R11 undefined op", vec_q, v);
        chk_bit("R11 undefined op", fault_q, 1'b1);
        issue(1'b1, 4'd15, 2'b11, B0, B0, M0, 32'h0);
        chk_gpr("R11 undefined op", gpr_q, g);
        issue(1'b1, 4'd1, 2'b00, A0, B0, M0, 32'h0);
        chk_gpr("R10 gpr kept", gpr_q, g);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_shuffle();
        t_unpack();
        t_merge();
        t_scalar();
        t_sign();
        t_align();
        t_hold();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule